// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switcher

This block picks the system root clock from up to eight oscillator inputs, each paired with a ready flag. Software controls it through two 32-bit words. The oscillator word holds a read-only field that shows the active source, a requested-source field, and a switch-start bit that clears itself. The slew word holds a 4-bit post-divider target, an interval field, two slew enables (one per direction), and a read-only busy flag.

To change source, software writes the requested source with the start bit set. The controller samples that source's synchronized ready flag. If the source is present and ready, the controller turns off the gate of the old clock on that clock's falling edge. It waits until the old gate is confirmed off, and only then turns on the gate of the new clock on the new clock's falling edge. If the source is absent, out of range or not ready, the request is dropped without any error indication. In every case the start bit clears when the request has been handled.

The root clock feeds a post-divider whose ratio is the field value plus one. When a slew enable covers the direction of a ratio change, the applied ratio moves one step per interval instead of jumping to the target.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, the oscillator word and the slew word both read zero. The applied ratio is 0, and the root clock runs from source 0.
- R2: Writing the oscillator word with bit 0 set starts a switch to the source in bits [10:8]. Bit 0 reads 1 on the cycle after the write. When the switch completes, bits [14:12] show the new source and bit 0 clears.
- R3: A request for a source whose ready flag is low is refused. Bit 0 clears, bits [14:12] keep their value, and the root clock keeps running from the old source.
- R4: At most one source gate is on at any time. The root clock never produces a pulse shorter than half the period of the fastest source.
- R5: While bit 0 is set, writes to the oscillator word are ignored, including the requested-source field.
- R6: Once a switch completes, the root clock period equals the period of the new source.
- R7: The divided clock period is (bits [23:20] of the slew word + 1) times the root clock period, after the applied ratio reaches the target.
- R8: Bit 0 of the slew word (busy) reads 1 from the cycle after a new target is written until the applied ratio equals the target and the ratio handover to the root domain is acknowledged. The applied ratio does not change while a handover is outstanding.
- R9: When the ratio rises with bit 1 set, or falls with bit 2 set, the applied ratio moves by exactly one per step. Steps are at least (bits [11:8] + 1) × SLEW_UNIT control cycles apart.
- R10: When the enable for the direction of change is clear, the applied ratio jumps to the target in one change.
- R11: Bits [14:12] of the oscillator word are read-only. Writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk_i | input | NSRC | Oscillator source clocks |
| src_ready_i | input | NSRC | Per-source ready flags (asynchronous) |
| wr_en_i | input | 1 | Word write strobe |
| wr_sel_i | input | 1 | 0 selects the oscillator word, 1 selects the slew word |
| wr_data_i | input | 32 | Write data |
| osc_word_o | output | 32 | Oscillator word readback |
| slew_word_o | output | 32 | Slew word readback |
| div_now_o | output | 4 | Applied post-divider code |
| sys_clk_o | output | 1 | Undivided root clock |
| sys_clk_div_o | output | 1 | Post-divided system clock |

## Verification
A source switch and a post-divider step can be in progress at the same time. Every divider handover is acknowledged in the root clock domain, and that clock stops during the break-before-make gap. The bench provokes the overlap by writing a stepped slew target and then, on the next cycle, requesting a new source. It judges the result by three things: the applied ratio still reaches the target in single steps, the switch completes to the requested source, and the divided clock period equals the new source period times the final ratio.

// File: rtl/sysclk_sw_pkg.sv
package sysclk_sw_pkg;
   localparam int WORD_W   = 32;
   localparam int SEL_W    = 3;
   localparam int DIV_W    = 4;
   localparam int IVL_W    = 4;
   // oscillator word fields
   localparam int START_BIT = 0;
   localparam int REQ_LSB   = 8;
   localparam int CUR_LSB   = 12;
   // slew word fields
   localparam int BUSY_BIT  = 0;
   localparam int DNEN_BIT  = 1;
   localparam int UPEN_BIT  = 2;
   localparam int IVL_LSB   = 8;
   localparam int DIV_LSB   = 20;

   typedef enum logic [1:0] {
      SW_IDLE,
      SW_CHECK,
      SW_DROP,
      SW_RAISE
   } sw_state_e;
endpackage

// File: rtl/sclk_gate_cell.sv
module sclk_gate_cell #(
   parameter bit RESET_ON = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_clk_i,
   input  logic en_i,
   output logic gated_o,
   output logic on_ack_o
);
   logic en_m, en_s, gate_q;
   logic ack_m, ack_s;

   // bring the request into the source domain
   always_ff @(posedge src_clk_i or negedge rst_n) begin
      if (!rst_n) begin
         en_m <= RESET_ON;
         en_s <= RESET_ON;
      end else begin
         en_m <= en_i;
         en_s <= en_m;
      end
   end

   // gate only changes while the source is low
   always_ff @(negedge src_clk_i or negedge rst_n) begin
      if (!rst_n) gate_q <= RESET_ON;
      else        gate_q <= en_s;
   end

   assign gated_o = src_clk_i & gate_q;

   // report gate state back to the control domain
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_m <= RESET_ON;
         ack_s <= RESET_ON;
      end else begin
         ack_m <= gate_q;
         ack_s <= ack_m;
      end
   end

   assign on_ack_o = ack_s;
endmodule

// File: rtl/sclk_switch_ctrl.sv
module sclk_switch_ctrl
   import sysclk_sw_pkg::*;
#(
   parameter int NSRC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SEL_W-1:0] req_sel_i,
   input  logic [NSRC-1:0]  ready_i,
   input  logic [NSRC-1:0]  ack_i,
   output logic [NSRC-1:0]  en_o,
   output logic [SEL_W-1:0] cur_o,
   output logic             swen_o
);
   localparam int CMP_W = SEL_W + 1;

   sw_state_e        state_q;
   logic [NSRC-1:0]  rdy_m, rdy_s, en_q;
   logic [SEL_W-1:0] cur_q, tgt_q;
   logic             swen_q, go_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_m <= '0;
         rdy_s <= '0;
      end else begin
         rdy_m <= ready_i;
         rdy_s <= rdy_m;
      end
   end

   assign go_ok = ({1'b0, tgt_q} < CMP_W'(NSRC)) && rdy_s[tgt_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SW_IDLE;
         swen_q  <= 1'b0;
         cur_q   <= '0;
         tgt_q   <= '0;
         en_q    <= NSRC'(1);
      end else begin
         case (state_q)
            SW_IDLE: if (start_i) begin
               swen_q  <= 1'b1;
               tgt_q   <= req_sel_i;
               state_q <= SW_CHECK;
            end
            SW_CHECK: begin
               if (!go_ok || tgt_q == cur_q) begin
                  swen_q  <= 1'b0;
                  state_q <= SW_IDLE;
               end else begin
                  en_q[cur_q] <= 1'b0;
                  state_q     <= SW_DROP;
               end
            end
            SW_DROP: if (!ack_i[cur_q]) begin
               en_q[tgt_q] <= 1'b1;
               state_q     <= SW_RAISE;
            end
            SW_RAISE: if (ack_i[tgt_q]) begin
               cur_q   <= tgt_q;
               swen_q  <= 1'b0;
               state_q <= SW_IDLE;
            end
            default: state_q <= SW_IDLE;
         endcase
      end
   end

   assign en_o   = en_q;
   assign cur_o  = cur_q;
   assign swen_o = swen_q;

   assert_cur_moves_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q != $past(cur_q)) |-> ($past(swen_q) && !swen_q));
   assert_refused_keeps_cur_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SW_CHECK && !go_ok) |=> (!swen_q && $stable(cur_q)));
   assert_single_gate_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ack_i));
endmodule

// File: rtl/sclk_slew_stepper.sv
module sclk_slew_stepper
   import sysclk_sw_pkg::*;
#(
   parameter int SLEW_UNIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] target_i,
   input  logic             dn_en_i,
   input  logic             up_en_i,
   input  logic [IVL_W-1:0] ivl_i,
   input  logic             ack_tog_i,
   output logic [DIV_W-1:0] applied_o,
   output logic             req_tog_o,
   output logic             busy_o
);
   localparam int CNT_W = IVL_W + $clog2(SLEW_UNIT) + 2;

   logic [DIV_W-1:0] applied_q, next_val;
   logic [CNT_W-1:0] wait_q, reload;
   logic             req_tog_q, ack_m, ack_s;
   logic             pending, ratio_up, step_mode, can_move;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_m <= 1'b0;
         ack_s <= 1'b0;
      end else begin
         ack_m <= ack_tog_i;
         ack_s <= ack_m;
      end
   end

   always_comb begin
      pending   = req_tog_q != ack_s;
      ratio_up  = target_i > applied_q;        // lower output frequency
      step_mode = ratio_up ? dn_en_i : up_en_i;
      if (!step_mode)    next_val = target_i;
      else if (ratio_up) next_val = applied_q + DIV_W'(1);
      else               next_val = applied_q - DIV_W'(1);
      can_move  = !pending && (wait_q == '0) && (applied_q != target_i);
      reload    = ((CNT_W'(ivl_i) + CNT_W'(1)) * CNT_W'(SLEW_UNIT)) - CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         applied_q <= '0;
         req_tog_q <= 1'b0;
         wait_q    <= '0;
      end else if (can_move) begin
         applied_q <= next_val;
         req_tog_q <= ~req_tog_q;
         wait_q    <= (step_mode && next_val != target_i) ? reload : '0;
      end else if (wait_q != '0) begin
         wait_q <= wait_q - CNT_W'(1);
      end
   end

   assign applied_o = applied_q;
   assign req_tog_o = req_tog_q;
   assign busy_o    = pending || (applied_q != target_i) || (wait_q != '0);

   assert_hold_during_handover_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_tog_q != ack_s) |=> $stable(applied_q));
   assert_single_step_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((applied_q != $past(applied_q)) && $past(dn_en_i) && ($past(target_i) > $past(applied_q)))
      |-> (applied_q == $past(applied_q) + DIV_W'(1)));
   assert_single_step_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((applied_q != $past(applied_q)) && $past(up_en_i) && ($past(target_i) < $past(applied_q)))
      |-> (applied_q == $past(applied_q) - DIV_W'(1)));
   assert_direct_jump_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((applied_q != $past(applied_q)) && !$past(dn_en_i) && ($past(target_i) > $past(applied_q)))
      |-> (applied_q == $past(target_i)));
endmodule

// File: rtl/sclk_div_gen.sv
module sclk_div_gen
   import sysclk_sw_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio_i,
   input  logic             req_tog_i,
   output logic             clk_div_o,
   output logic             ack_tog_o
);
   logic [DIV_W-1:0] ratio_q, cnt_q, ratio_nxt, cnt_nxt;
   logic [DIV_W:0]   half_nxt;
   logic             req_m, req_s, ack_q, out_q, period_end, load;

   always_comb begin
      period_end = cnt_q == ratio_q;
      load       = period_end && (req_s != ack_q);
      ratio_nxt  = load ? ratio_i : ratio_q;
      cnt_nxt    = period_end ? '0 : cnt_q + DIV_W'(1);
      half_nxt   = ({1'b0, ratio_nxt} + (DIV_W+1)'(2)) >> 1;
   end

   always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
         req_m   <= 1'b0;
         req_s   <= 1'b0;
         ack_q   <= 1'b0;
         ratio_q <= '0;
         cnt_q   <= '0;
         out_q   <= 1'b1;
      end else begin
         req_m   <= req_tog_i;
         req_s   <= req_m;
         ratio_q <= ratio_nxt;
         cnt_q   <= cnt_nxt;
         out_q   <= {1'b0, cnt_nxt} < half_nxt;
         if (load) ack_q <= req_s;
      end
   end

   assign clk_div_o = (ratio_q == '0) ? clk_i : out_q;
   assign ack_tog_o = ack_q;

   assert_count_in_window_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
      cnt_q <= ratio_q);
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
   import sysclk_sw_pkg::*;
#(
   parameter int NSRC      = 8,
   parameter int SLEW_UNIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_clk_i,
   input  logic [NSRC-1:0]   src_ready_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [WORD_W-1:0] osc_word_o,
   output logic [WORD_W-1:0] slew_word_o,
   output logic [DIV_W-1:0]  div_now_o,
   output logic              sys_clk_o,
   output logic              sys_clk_div_o
);
   if (NSRC < 2 || NSRC > (1 << SEL_W)) begin : g_bad_nsrc
      initial $error("sysclk_switch: NSRC must lie in 2..%0d", 1 << SEL_W);
   end
   if (SLEW_UNIT < 1) begin : g_bad_unit
      initial $error("sysclk_switch: SLEW_UNIT must be positive");
   end

   logic [SEL_W-1:0] req_q, cur;
   logic [DIV_W-1:0] tgt_q, applied;
   logic [IVL_W-1:0] ivl_q;
   logic             dn_en_q, up_en_q, swen, start, busy;
   logic             req_tog, ack_tog;
   logic [NSRC-1:0]  gate_en, gate_ack, gated;
   logic             unused_wr;

   assign unused_wr = ^{wr_data_i[31:24], wr_data_i[19:12], wr_data_i[7:3]};

   assign start = wr_en_i && !wr_sel_i && wr_data_i[START_BIT] && !swen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q   <= '0;
         tgt_q   <= '0;
         ivl_q   <= '0;
         dn_en_q <= 1'b0;
         up_en_q <= 1'b0;
      end else if (wr_en_i) begin
         if (!wr_sel_i) begin
            if (!swen) req_q <= wr_data_i[REQ_LSB +: SEL_W];
         end else begin
            tgt_q   <= wr_data_i[DIV_LSB +: DIV_W];
            ivl_q   <= wr_data_i[IVL_LSB +: IVL_W];
            dn_en_q <= wr_data_i[DNEN_BIT];
            up_en_q <= wr_data_i[UPEN_BIT];
         end
      end
   end

   sclk_switch_ctrl #(.NSRC(NSRC)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start),
      .req_sel_i (wr_data_i[REQ_LSB +: SEL_W]),
      .ready_i   (src_ready_i),
      .ack_i     (gate_ack),
      .en_o      (gate_en),
      .cur_o     (cur),
      .swen_o    (swen)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_cell
      sclk_gate_cell #(.RESET_ON(i == 0)) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .src_clk_i (src_clk_i[i]),
         .en_i      (gate_en[i]),
         .gated_o   (gated[i]),
         .on_ack_o  (gate_ack[i])
      );
   end

   assign sys_clk_o = |gated;

   sclk_slew_stepper #(.SLEW_UNIT(SLEW_UNIT)) u_slew (
      .clk       (clk),
      .rst_n     (rst_n),
      .target_i  (tgt_q),
      .dn_en_i   (dn_en_q),
      .up_en_i   (up_en_q),
      .ivl_i     (ivl_q),
      .ack_tog_i (ack_tog),
      .applied_o (applied),
      .req_tog_o (req_tog),
      .busy_o    (busy)
   );

   sclk_div_gen u_div (
      .clk_i     (sys_clk_o),
      .rst_n     (rst_n),
      .ratio_i   (applied),
      .req_tog_i (req_tog),
      .clk_div_o (sys_clk_div_o),
      .ack_tog_o (ack_tog)
   );

   always_comb begin
      osc_word_o = '0;
      osc_word_o[CUR_LSB +: SEL_W] = cur;
      osc_word_o[REQ_LSB +: SEL_W] = req_q;
      osc_word_o[START_BIT]        = swen;
      slew_word_o = '0;
      slew_word_o[DIV_LSB +: DIV_W] = tgt_q;
      slew_word_o[IVL_LSB +: IVL_W] = ivl_q;
      slew_word_o[UPEN_BIT]         = up_en_q;
      slew_word_o[DNEN_BIT]         = dn_en_q;
      slew_word_o[BUSY_BIT]         = busy;
   end

   assign div_now_o = applied;

   assert_req_locked_while_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_sel_i && swen) |=> $stable(req_q));
endmodule

// File: tb/tb_sysclk_switch.sv
`timescale 1ns/100ps
module tb_sysclk_switch;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   wire  [7:0]  src_clk;
   logic [7:0]  ready = 8'b0101_1111;
   logic        wr_en = 1'b0, wr_sel = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] osc_word, slew_word;
   logic [3:0]  div_now;
   logic        sys_clk, sys_clk_div;

   int n_chk = 0, n_fail = 0;

   always #2 clk = ~clk;

   // source i has period 6 + 2*i ns
   for (genvar g = 0; g < 8; g++) begin : g_src
      logic s = 1'b0;
      always #(3 + g) s = ~s;
      assign src_clk[g] = s;
   end

   sysclk_switch dut (
      .clk(clk), .rst_n(rst_n), .src_clk_i(src_clk), .src_ready_i(ready),
      .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
      .osc_word_o(osc_word), .slew_word_o(slew_word), .div_now_o(div_now),
      .sys_clk_o(sys_clk), .sys_clk_div_o(sys_clk_div)
   );

   // root clock pulse-width monitor
   realtime last_edge = 0.0;
   bit      mon_on = 1'b0;
   int      glitches = 0;
   always @(sys_clk) begin
      if (mon_on && ($realtime - last_edge) < 2.9) glitches++;
      last_edge = $realtime;
   end

   // applied-ratio change monitor
   int  chg_cnt = 0, max_step = 0, min_gap = 1000000, gap = 0;
   bit  seen_chg = 1'b0;
   logic [3:0] prev_div = '0;
   always @(negedge clk) begin
      gap++;
      if (div_now != prev_div) begin
         chg_cnt++;
         if (seen_chg && gap < min_gap) min_gap = gap;
         if ((div_now > prev_div ? div_now - prev_div : prev_div - div_now) > max_step)
            max_step = div_now > prev_div ? div_now - prev_div : prev_div - div_now;
         seen_chg = 1'b1;
         gap = 0;
      end
      prev_div = div_now;
   end

   task automatic mon_clear();
      chg_cnt = 0; max_step = 0; min_gap = 1000000; seen_chg = 1'b0; gap = 0;
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic wr(input bit sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_swen(input string tag);
      int k = 0;
      while (osc_word[0] && k < 4000) begin @(negedge clk); k++; end
      chk(!osc_word[0], tag, int'(osc_word[0]), 0);
   endtask

   task automatic wait_busy(input string tag);
      int k = 0;
      while (slew_word[0] && k < 8000) begin @(negedge clk); k++; end
      chk(!slew_word[0], tag, int'(slew_word[0]), 0);
   endtask

   task automatic meas_sys(input int exp_ns, input string tag);
      realtime t0;
      repeat (3) @(posedge sys_clk);
      t0 = $realtime;
      @(posedge sys_clk);
      chk(int'(($realtime - t0) * 10) == exp_ns * 10, tag, int'(($realtime - t0) * 10), exp_ns * 10);
   endtask

   task automatic meas_div(input int exp_ns, input string tag);
      realtime t0;
      repeat (3) @(posedge sys_clk_div);
      t0 = $realtime;
      @(posedge sys_clk_div);
      chk(int'(($realtime - t0) * 10) == exp_ns * 10, tag, int'(($realtime - t0) * 10), exp_ns * 10);
   endtask

   task automatic t_reset();
      chk(osc_word == 32'h0, "R1 osc word", int'(osc_word), 0);
      chk(slew_word == 32'h0, "R1 slew word", int'(slew_word), 0);
      chk(div_now == 4'd0, "R1 ratio", int'(div_now), 0);
      meas_sys(6, "R1 source 0 period");
   endtask

   task automatic t_switch(input int s, input int per);
      wr(1'b0, 32'h1 | (s << 8));
      chk(osc_word[0], "R2 start bit set", int'(osc_word[0]), 1);
      wait_swen("R2 start bit clears");
      chk(osc_word[14:12] == 3'(s), "R2 current source", int'(osc_word[14:12]), s);
      meas_sys(per, "R6 root period");
   endtask

   task automatic t_refuse();
      wr(1'b0, 32'h501);
      wait_swen("R3 start bit clears");
      chk(osc_word[14:12] == 3'd3, "R3 current kept", int'(osc_word[14:12]), 3);
      chk(osc_word[10:8] == 3'd5, "R3 request field", int'(osc_word[10:8]), 5);
      meas_sys(12, "R3 old clock runs");
   endtask

   task automatic t_locked();
      wr(1'b0, 32'h201);
      wr(1'b0, 32'h601);
      wait_swen("R5 switch ends");
      chk(osc_word[10:8] == 3'd2, "R5 request kept", int'(osc_word[10:8]), 2);
      chk(osc_word[14:12] == 3'd2, "R5 first request wins", int'(osc_word[14:12]), 2);
   endtask

   task automatic t_readonly();
      wr(1'b0, 32'h0000_7200);
      repeat (20) @(negedge clk);
      chk(osc_word[14:12] == 3'd2, "R11 current not writable", int'(osc_word[14:12]), 2);
      meas_sys(10, "R11 clock unchanged");
   endtask

   task automatic t_div(input logic [31:0] d, input int fin, input int steps,
                        input int step_max, input int per, input string tag);
      mon_clear();
      wr(1'b1, d);
      chk(slew_word[0], {tag, " R8 busy raised"}, int'(slew_word[0]), 1);
      wait_busy({tag, " R8 busy cleared"});
      chk(div_now == 4'(fin), {tag, " ratio reached"}, int'(div_now), fin);
      chk(chg_cnt == steps, {tag, " change count"}, chg_cnt, steps);
      chk(max_step <= step_max, {tag, " step size"}, max_step, step_max);
      if (steps > 1)
         chk(min_gap >= (int'(d[11:8]) + 1) * 4, {tag, " R9 interval"}, min_gap, (int'(d[11:8]) + 1) * 4);
      meas_div(per, {tag, " R7 divided period"});
   endtask

   task automatic t_overlap();
      mon_clear();
      wr(1'b1, (32'd2 << 20) | 32'h2);
      wr(1'b0, 32'h301);
      wait_swen("R6 overlap switch");
      wait_busy("R9 overlap slew");
      chk(osc_word[14:12] == 3'd3, "R6 overlap source", int'(osc_word[14:12]), 3);
      chk(div_now == 4'd2 && max_step == 1, "R9 overlap ratio", int'(div_now), 2);
      meas_div(36, "R7 overlap divided period");
   endtask

   initial begin : watchdog
      #400000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      mon_on = 1'b1;
      t_reset();
      t_switch(3, 12);
      t_refuse();
      t_switch(3, 12);
      t_locked();
      t_readonly();
      @(negedge clk) ready[5] = 1'b1;
      t_switch(5, 16);
      t_switch(0, 6);
      t_div(32'd3 << 20, 3, 1, 3, 24, "R10 jump down");
      t_div((32'd7 << 20) | (32'd2 << 8) | 32'h2, 7, 4, 1, 48, "R9 slew down");
      t_div((32'd1 << 20) | (32'd2 << 8) | 32'h4, 1, 6, 1, 12, "R9 slew up");
      t_div((32'd6 << 20) | 32'h4, 6, 1, 5, 42, "R10 jump up-ratio");
      t_div(32'h2, 0, 1, 6, 6, "R10 jump to bypass");
      t_overlap();
      chk(glitches == 0, "R4 short pulses", glitches, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule